// File: doc/BRIEF.md
# Selectable Line Test Pattern Generator

This block drives one serial bit per enabled clock onto a digital line test port. A 4-bit code picks one of nine behaviours. Eight of them are active patterns. Four are repeated fixed words: a sparse three-marks-per-24-bits word, a one-in-eight word, all zeros and all ones. Two are pseudo-random sequences, a 20-stage one and a 15-stage one. One is the 20-stage sequence with long zero runs broken up. The last is a 55-octet sequence that swings from sparse octets to dense ones. The ninth code, and every unused code, keeps the port quiet.

The output is registered. The bit for an enabled clock edge appears on `dout`, with `dvalid` high, just after that edge. Changing the select code restarts the new pattern from its first bit. Dropping the enable freezes the pattern where it stands.

Top module: `line_pattern_gen`

## Requirements
- R1: During reset, and on the clock edge where `sel` differs from the code in use, `dout` and `dvalid` go to 0. The pattern state is reseeded, so the next enabled edge emits the first bit of the new pattern.
- R2: Code 1 and every code outside 2..9 keep `dout` and `dvalid` at 0.
- R3: On an edge with `en` low, `dout` and `dvalid` go to 0 and the pattern does not advance. The next enabled edge continues from the bit that was due.
- R4: Code 2 repeats the 24-bit word 0x888000, most significant bit first (1000 1000 1000 0000 0000 0000).
- R5: Code 5 repeats the octet 0x80, most significant bit first: one mark, then seven zeros.
- R6: Code 7 emits constant 0 and code 9 emits constant 1, both with `dvalid` high.
- R7: Code 4 emits bits b[n] with b[0..19] all 1 and b[n+20] = b[n] xor b[n+3]. This is the 20-stage x^20+x^17+1 sequence, with period 1,048,575.
- R8: Code 3 follows the R7 sequence, except that a bit is forced to 1 whenever the 14 previously emitted bits were all 0. The output therefore never holds more than 14 consecutive zeros.
- R9: Code 6 emits the inverse of r[n], where r[0..14] are all 1 and r[n+15] = r[n] xor r[n+1]. The output repeats every 32,767 bits.
- R10: Code 8 sends 55 octets, each most significant bit first. Octets 0..29 alternate 0x80 (even index) and 0x01 (odd index). Octets 30..54 alternate 0xFF (even) and 0xAA (odd). After octet 54 the sequence wraps to octet 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the pattern one bit on this edge |
| sel | input | 4 | Pattern select code |
| dout | output | 1 | Serial test bit |
| dvalid | output | 1 | High when `dout` carries a pattern bit |

## Verification
Some rules are checked by the assertions on every cycle. `dvalid` is only high after an enabled edge, and `dout` stays low whenever `dvalid` is low. A code change always blanks the following output, inactive codes stay quiet, and all-ones mode never emits a zero. The observed zero run in the suppressed mode never exceeds 14. Neither pseudo-random register ever reaches the all-zero state, and the octet index never leaves the ROM.

The assertions cannot show that the bit values are right. That comes only from the bench's reference model, compared on every clock. The model checks the word contents and bit order, the exact recurrences of both sequences, where the forced ones land, the 32,767-bit period and the octet wrap. It also checks that a pattern resumes correctly after an enable gap.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
   typedef enum logic [3:0] {
      PAT_NONE  = 4'd1,
      PAT_3IN24 = 4'd2,
      PAT_QRSS  = 4'd3,
      PAT_PN20  = 4'd4,
      PAT_1IN8  = 4'd5,
      PAT_PN15  = 4'd6,
      PAT_ZEROS = 4'd7,
      PAT_DALY  = 4'd8,
      PAT_ONES  = 4'd9
   } pat_sel_e;
endpackage

// File: rtl/lpg_lfsr.sv
module lpg_lfsr #(
   parameter int W      = 20,
   parameter int TAP    = 17,
   parameter bit INVERT = 1'b0
) (
   input  logic clk,
   input  logic restart,
   input  logic step,
   output logic bit_o
);
   if (W < 3 || TAP < 1 || TAP >= W) begin : g_bad_cfg
      $error("lpg_lfsr: TAP must lie in 1..W-1 and W must be at least 3");
   end

   logic [W-1:0] sr;
   logic         fb;

   assign fb    = sr[W-1] ^ sr[TAP-1];
   assign bit_o = sr[W-1] ^ INVERT;

   always_ff @(posedge clk) begin
      if (restart)   sr <= '1;
      else if (step) sr <= {sr[W-2:0], fb};
   end

   // R7 / R9: the register must never lock up in the all-zero state
   p_lfsr_live_r7: assert property (@(posedge clk) disable iff (restart)
      sr != '0);
endmodule

// File: rtl/lpg_word_seq.sv
module lpg_word_seq #(
   parameter int           W    = 24,
   parameter logic [W-1:0] WORD = 24'h888000
) (
   input  logic clk,
   input  logic restart,
   input  logic step,
   output logic bit_o
);
   localparam int            CW   = (W > 1) ? $clog2(W) : 1;
   localparam logic [CW-1:0] LAST = CW'(W - 1);
   localparam bit            POW2 = ((1 << CW) == W);

   if (W < 2) begin : g_bad_cfg
      $error("lpg_word_seq: word must be at least 2 bits");
   end

   logic [CW-1:0] pos;

   assign bit_o = WORD[LAST - pos];

   if (POW2) begin : g_wrap_free
      always_ff @(posedge clk) begin
         if (restart)   pos <= '0;
         else if (step) pos <= pos + 1'b1;
      end
   end else begin : g_wrap_cmp
      always_ff @(posedge clk) begin
         if (restart)   pos <= '0;
         else if (step) pos <= (pos == LAST) ? '0 : pos + 1'b1;
      end
      // R4: the bit position stays inside the word
      p_word_pos_r4: assert property (@(posedge clk) disable iff (restart)
         pos <= LAST);
   end
endmodule

// File: rtl/lpg_octet_rom.sv
module lpg_octet_rom #(
   parameter int         DEPTH     = 55,
   parameter int         LOW_CNT   = 30,
   parameter logic [7:0] LOW_EVEN  = 8'h80,
   parameter logic [7:0] LOW_ODD   = 8'h01,
   parameter logic [7:0] HIGH_EVEN = 8'hFF,
   parameter logic [7:0] HIGH_ODD  = 8'hAA
) (
   input  logic clk,
   input  logic restart,
   input  logic step,
   output logic bit_o
);
   localparam int            IW   = $clog2(DEPTH);
   localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

   if (DEPTH < 2 || LOW_CNT > DEPTH) begin : g_bad_cfg
      $error("lpg_octet_rom: need DEPTH >= 2 and LOW_CNT <= DEPTH");
   end

   logic [7:0]    rom [DEPTH];
   logic [IW-1:0] idx;
   logic [2:0]    bsel;

   for (genvar i = 0; i < DEPTH; i++) begin : g_rom
      localparam logic [7:0] VAL = (i < LOW_CNT)
         ? (((i % 2) == 0) ? LOW_EVEN  : LOW_ODD)
         : (((i % 2) == 0) ? HIGH_EVEN : HIGH_ODD);
      assign rom[i] = VAL;
   end

   assign bit_o = rom[idx][3'd7 - bsel];

   always_ff @(posedge clk) begin
      if (restart) begin
         idx  <= '0;
         bsel <= '0;
      end else if (step) begin
         bsel <= bsel + 1'b1;
         if (bsel == 3'd7) idx <= (idx == LAST) ? '0 : idx + 1'b1;
      end
   end

   // R10: the octet index wraps before leaving the table
   p_octet_index_r10: assert property (@(posedge clk) disable iff (restart)
      idx <= LAST);
endmodule

// File: rtl/line_pattern_gen.sv
module line_pattern_gen
   import lpg_pkg::*;
#(
   parameter int PN_LONG_W    = 20,
   parameter int PN_LONG_TAP  = 17,
   parameter int PN_SHORT_W   = 15,
   parameter int PN_SHORT_TAP = 14,
   parameter int ZRUN_LIMIT   = 14,
   parameter int DALY_DEPTH   = 55,
   parameter int DALY_LOW     = 30
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       en,
   input  logic [3:0] sel,
   output logic       dout,
   output logic       dvalid
);
   localparam int ZW = $clog2(ZRUN_LIMIT + 1);

   if (ZRUN_LIMIT < 1 || ZRUN_LIMIT > 15) begin : g_bad_cfg
      $error("line_pattern_gen: ZRUN_LIMIT must be in 1..15");
   end

   logic [3:0]    sel_q;
   logic          restart, step;
   logic          w24_bit, w8_bit, pn20_bit, pn15_bit, daly_bit, qrss_bit;
   logic [ZW-1:0] zcnt;
   logic          pat_bit, pat_active;

   assign restart = rst | (sel != sel_q);
   assign step    = en & ~restart;

   lpg_word_seq #(.W(24), .WORD(24'h888000)) i_w24 (
      .clk(clk), .restart(restart), .step(step), .bit_o(w24_bit));

   lpg_word_seq #(.W(8), .WORD(8'h80)) i_w8 (
      .clk(clk), .restart(restart), .step(step), .bit_o(w8_bit));

   lpg_lfsr #(.W(PN_LONG_W), .TAP(PN_LONG_TAP), .INVERT(1'b0)) i_pn20 (
      .clk(clk), .restart(restart), .step(step), .bit_o(pn20_bit));

   lpg_lfsr #(.W(PN_SHORT_W), .TAP(PN_SHORT_TAP), .INVERT(1'b1)) i_pn15 (
      .clk(clk), .restart(restart), .step(step), .bit_o(pn15_bit));

   lpg_octet_rom #(.DEPTH(DALY_DEPTH), .LOW_CNT(DALY_LOW)) i_daly (
      .clk(clk), .restart(restart), .step(step), .bit_o(daly_bit));

   // zero-run suppression for the quasi-random mode
   assign qrss_bit = (zcnt == ZW'(ZRUN_LIMIT)) ? 1'b1 : pn20_bit;

   always_ff @(posedge clk) begin
      if (restart)                        zcnt <= '0;
      else if (step && sel_q == PAT_QRSS) zcnt <= qrss_bit ? '0 : zcnt + 1'b1;
   end

   always_comb begin
      pat_active = 1'b1;
      pat_bit    = 1'b0;
      case (sel_q)
         PAT_3IN24: pat_bit = w24_bit;
         PAT_QRSS:  pat_bit = qrss_bit;
         PAT_PN20:  pat_bit = pn20_bit;
         PAT_1IN8:  pat_bit = w8_bit;
         PAT_PN15:  pat_bit = pn15_bit;
         PAT_ZEROS: pat_bit = 1'b0;
         PAT_DALY:  pat_bit = daly_bit;
         PAT_ONES:  pat_bit = 1'b1;
         default:   pat_active = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (restart) begin
         sel_q  <= sel;
         dout   <= 1'b0;
         dvalid <= 1'b0;
      end else begin
         dvalid <= en & pat_active;
         dout   <= en & pat_active & pat_bit;
      end
   end

   // observed zero run on the output port, suppressed mode
   logic [ZW:0] obs_run;
   always_ff @(posedge clk) begin
      if (restart)     obs_run <= '0;
      else if (dvalid) obs_run <= dout ? '0 : obs_run + 1'b1;
   end

   p_zero_run_r8: assert property (@(posedge clk) disable iff (rst)
      (sel_q == PAT_QRSS) |-> (obs_run <= (ZW+1)'(ZRUN_LIMIT)));

   p_valid_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
      dvalid |-> $past(en));

   p_quiet_when_invalid_r2: assert property (@(posedge clk) disable iff (rst)
      !dvalid |-> !dout);

   p_inactive_code_r2: assert property (@(posedge clk) disable iff (rst)
      !(sel inside {[4'd2:4'd9]}) |=> !dvalid);

   p_restart_blank_r1: assert property (@(posedge clk) disable iff (rst)
      (sel != $past(sel)) |=> !dvalid);

   p_ones_mode_r6: assert property (@(posedge clk) disable iff (rst)
      (dvalid && sel_q == PAT_ONES) |-> dout);
endmodule

// File: tb/test_line_pattern_gen.sv
module test_line_pattern_gen;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en  = 1'b0;
   logic [3:0] sel = 4'd3;
   logic       dout, dvalid;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   line_pattern_gen i_line_pattern_gen (
      .clk(clk), .rst(rst), .en(en), .sel(sel), .dout(dout), .dvalid(dvalid));

   // behavioural reference model
   logic [3:0] m_sel = 4'd0;
   bit         q20[$];
   bit         q15[$];
   int         pos  = 0;
   int         zrun = 0;
   logic       exp_d = 1'b0, exp_v = 1'b0;
   string      tag = "R1";

   function automatic logic [7:0] daly_byte(int i);
      if (i < 30) return (i % 2 == 0) ? 8'h80 : 8'h01;
      return (i % 2 == 0) ? 8'hFF : 8'hAA;
   endfunction

   task automatic model_step();
      bit raw, nb;
      logic [23:0] w24;
      logic [7:0]  oct;
      w24 = 24'h888000;
      if (rst || sel != m_sel) begin
         m_sel = sel;
         q20.delete();
         q15.delete();
         repeat (20) q20.push_back(1'b1);
         repeat (15) q15.push_back(1'b1);
         pos = 0; zrun = 0; exp_d = 0; exp_v = 0; tag = "R1";
      end else if (!en) begin
         exp_d = 0; exp_v = 0; tag = "R3";
      end else begin
         exp_v = 1;
         case (m_sel)
            4'd2: begin exp_d = w24[23 - (pos % 24)]; tag = "R4"; end
            4'd5: begin exp_d = (pos % 8 == 0); tag = "R5"; end
            4'd7: begin exp_d = 0; tag = "R6"; end
            4'd9: begin exp_d = 1; tag = "R6"; end
            4'd8: begin
               oct = daly_byte((pos / 8) % 55);
               exp_d = oct[7 - (pos % 8)]; tag = "R10";
            end
            4'd3, 4'd4: begin
               nb  = q20[0] ^ q20[3];
               raw = q20.pop_front();
               q20.push_back(nb);
               if (m_sel == 4'd4) begin
                  exp_d = raw; tag = "R7";
               end else begin
                  exp_d = (zrun >= 14) ? 1'b1 : raw;
                  zrun  = exp_d ? 0 : zrun + 1;
                  tag   = "R8";
               end
            end
            4'd6: begin
               nb  = q15[0] ^ q15[1];
               raw = q15.pop_front();
               q15.push_back(nb);
               exp_d = ~raw; tag = "R9";
            end
            default: begin exp_v = 0; exp_d = 0; tag = "R2"; end
         endcase
         if (exp_v) pos++;
      end
   endtask

   task automatic compare();
      checks++;
      if (dout !== exp_d || dvalid !== exp_v) begin
         failures++;
         $display("FAIL %s: sel=%0d en=%b dout=%b dvalid=%b expected dout=%b dvalid=%b",
                  tag, sel, en, dout, dvalid, exp_d, exp_v);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
   endtask

   task automatic run(int n);
      repeat (n) tick();
   endtask

   initial begin
      logic first_bits [40];
      int   run0, max_run;
      @(negedge clk);
      run(3);                              // R1: reset state
      rst = 1'b0; en = 1'b1;
      sel = 4'd2; run(60);                 // R4
      sel = 4'd5; run(30);                 // R5
      sel = 4'd7; run(20);                 // R6
      sel = 4'd9; run(20);                 // R6
      sel = 4'd8; run(55 * 8 * 2 + 24);    // R10 with wrap
      sel = 4'd4; run(3000);               // R7
      sel = 4'd1; run(10);                 // R2
      sel = 4'd12; run(10);                // R2
      sel = 4'd0; run(5);                  // R2
      sel = 4'd15; run(5);                 // R2
      // R3: enable gaps inside a fixed word and the octet sequence
      sel = 4'd2; tick();
      for (int k = 0; k < 60; k++) begin en = (k % 3 != 2); tick(); end
      sel = 4'd8; en = 1'b1; tick();
      for (int k = 0; k < 120; k++) begin en = (k % 5 < 3); tick(); end
      // R1: switch mid-pattern, back and restart
      en = 1'b1; sel = 4'd5; run(13);
      sel = 4'd2; run(30);
      rst = 1'b1; run(2); rst = 1'b0; run(30);
      // R8: suppressed sequence, with run tracking at the port
      sel = 4'd3; tick();
      run0 = 0; max_run = 0;
      for (int k = 0; k < 60000; k++) begin
         en = (k % 997 != 500);
         tick();
         if (dvalid) begin
            run0 = dout ? 0 : run0 + 1;
            if (run0 > max_run) max_run = run0;
         end
      end
      checks++;
      if (max_run > 14) begin
         failures++;
         $display("FAIL R8: longest zero run %0d expected at most 14", max_run);
      end
      // R9: short sequence and its period
      en = 1'b1; sel = 4'd6; tick();
      for (int k = 0; k < 32767 + 40; k++) begin
         tick();
         if (k < 40) first_bits[k] = dout;
         else if (k >= 32767) begin
            checks++;
            if (dout !== first_bits[k - 32767]) begin
               failures++;
               $display("FAIL R9: bit %0d = %b expected %b (period)",
                        k, dout, first_bits[k - 32767]);
            end
         end
      end
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule